// File: doc/BRIEF.md
# PCI Host Bus Bring-Up Sequencer

This block powers up an external PCI bus from the host side once system reset has gone away. After a single start pulse it walks a fixed, timed order. First it turns on the output drivers for the bus reset and the bus clock. Next it starts the clock and holds the bus in reset for a long interval. It then releases reset and hands arbitration to the internal arbiter, which gets a short hold. Last, it loads three address-window registers and waits for a long settle interval before it raises `ready`.

Every interval is given in microseconds and converted to system-clock cycles from the clock-frequency parameter. A divisor parameter shortens all intervals by the same ratio for fast tests, and no interval is ever shorter than one cycle. The control bits stay set once they are reached, and so do the window values. Only system reset takes the block back to idle with all drivers off. A start pulse that arrives after the block has left idle is ignored.

Top module: `pcib_bringup`

## Requirements
- R1: While `rst_n` is low and straight after it goes high, all five control outputs, the three window outputs and `ready` are zero.
- R2: A start pulse sampled in idle sets `bus_rst_oe` and `bus_clk_oe` after that clock edge (cycle 0). `bus_clk_run` and `bus_rst_release` stay 0 during that cycle.
- R3: One cycle after the drivers are enabled (cycle 1), `bus_clk_run` goes to 1 while `bus_rst_release` is still 0.
- R4: `bus_rst_release` rises HOLD cycles after `bus_clk_run`, at cycle 1+HOLD. HOLD = max(1, CLK_HZ/1e6 * 150 / TIME_DIV).
- R5: `arb_internal` rises one cycle after release, at cycle 2+HOLD. It is held for ARB = max(1, CLK_HZ/1e6 * 1 / TIME_DIV) cycles before any window is written.
- R6: The windows are written one per cycle in a fixed order: I/O at cycle 3+HOLD+ARB, configuration at 4+HOLD+ARB, memory at 5+HOLD+ARB. Each value is its aligned base OR'd with a 2-bit type code in bits [1:0]: I/O = 01, configuration Type 0 = 10, memory = 00. With the default parameters the values are 32'h0800_0001, 32'h0C00_0002 and 32'h4000_0000.
- R7: `ready` rises SETTLE = max(1, CLK_HZ/1e6 * 10000 / TIME_DIV) cycles after the memory window is written, at cycle 5+HOLD+ARB+SETTLE. It then stays high.
- R8: A start pulse has no effect on any output while a sequence is running or after `ready`.
- R9: Driving `rst_n` low in the middle of a sequence returns every output to zero at once. A later start pulse then replays the full timeline from R2 to R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| start | input | 1 | Request to begin bring-up, sampled in idle |
| bus_rst_oe | output | 1 | Output enable for the bus reset driver |
| bus_clk_oe | output | 1 | Output enable for the bus clock driver |
| bus_clk_run | output | 1 | Bus clock running |
| bus_rst_release | output | 1 | Bus reset deasserted |
| arb_internal | output | 1 | Internal arbiter selected |
| win_io | output | WIN_W | I/O window value |
| win_cfg | output | WIN_W | Configuration window value (Type 0) |
| win_mem | output | WIN_W | Memory window value |
| ready | output | 1 | Bring-up complete |

## Verification
A reference timeline of output changes is computed from the interval formulas and compared, change by change, with what the block drives. Any step that comes early or late, is skipped or comes in the wrong order is therefore caught. One run receives an extra start pulse during the reset hold. A second pulse arrives after `ready`. Either pulse, if it were not ignored, would move the timeline or add an unexpected change. A reset in the middle of the hold, followed by a fresh start, shows that no partly counted delay or window value survives reset. The exact window values tell a wrong type code or base apart from a wrong write order.

// File: rtl/pcib_pkg.sv
package pcib_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_DRV,
      S_CLK,
      S_REL,
      S_ARB,
      S_WIO,
      S_WCFG,
      S_WMEM,
      S_SETTLE,
      S_READY
   } seq_state_e;

   typedef struct packed {
      logic arb_int;
      logic rst_rel;
      logic clk_run;
      logic clk_oe;
      logic rst_oe;
   } bus_ctl_t;

   localparam int unsigned NUM_WIN   = 3;
   localparam int unsigned WIN_IDX_IO  = 0;
   localparam int unsigned WIN_IDX_CFG = 1;
   localparam int unsigned WIN_IDX_MEM = 2;

   localparam logic [1:0] WTYPE_MEM  = 2'b00;
   localparam logic [1:0] WTYPE_IO   = 2'b01;
   localparam logic [1:0] WTYPE_CFG0 = 2'b10;

   function automatic int unsigned delay_cycles(input int unsigned mhz,
                                                input int unsigned us,
                                                input int unsigned div);
      int unsigned v;
      v = (mhz * us) / div;
      return (v < 1) ? 1 : v;
   endfunction

endpackage

// File: rtl/pcib_delay_timer.sv
module pcib_delay_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
   end

   assign zero = (cnt_q == '0);
endmodule

// File: rtl/pcib_seq_fsm.sv
module pcib_seq_fsm
   import pcib_pkg::*;
#(
   parameter int unsigned CNT_W      = 8,
   parameter int unsigned HOLD_CYC   = 4,
   parameter int unsigned ARB_CYC    = 1,
   parameter int unsigned SETTLE_CYC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               tmr_zero,
   output logic               tmr_load,
   output logic [CNT_W-1:0]   tmr_val,
   output bus_ctl_t           ctl,
   output logic [NUM_WIN-1:0] win_wr,
   output logic               done
);
   localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);
   localparam logic [CNT_W-1:0] ARB_LD    = CNT_W'(ARB_CYC - 1);
   localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);

   seq_state_e st_q, st_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= S_IDLE;
      else        st_q <= st_d;
   end

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (st_q)
         S_IDLE:   if (start) st_d = S_DRV;
         S_DRV: begin
            st_d     = S_CLK;
            tmr_load = 1'b1;
            tmr_val  = HOLD_LD;
         end
         S_CLK:    if (tmr_zero) st_d = S_REL;
         S_REL: begin
            st_d     = S_ARB;
            tmr_load = 1'b1;
            tmr_val  = ARB_LD;
         end
         S_ARB:    if (tmr_zero) st_d = S_WIO;
         S_WIO:    st_d = S_WCFG;
         S_WCFG:   st_d = S_WMEM;
         S_WMEM: begin
            st_d     = S_SETTLE;
            tmr_load = 1'b1;
            tmr_val  = SETTLE_LD;
         end
         S_SETTLE: if (tmr_zero) st_d = S_READY;
         S_READY:  st_d = S_READY;
         default:  st_d = S_IDLE;
      endcase
   end

   always_comb begin
      ctl.rst_oe  = (st_q != S_IDLE);
      ctl.clk_oe  = (st_q != S_IDLE);
      ctl.clk_run = (st_q >= S_CLK);
      ctl.rst_rel = (st_q >= S_REL);
      ctl.arb_int = (st_q >= S_ARB);
   end

   assign win_wr[WIN_IDX_IO]  = (st_q == S_WIO);
   assign win_wr[WIN_IDX_CFG] = (st_q == S_WCFG);
   assign win_wr[WIN_IDX_MEM] = (st_q == S_WMEM);
   assign done                = (st_q == S_READY);
endmodule

// File: rtl/pcib_window_regs.sv
module pcib_window_regs #(
   parameter int unsigned N     = 3,
   parameter int unsigned WIN_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N-1:0]            wr,
   input  logic [N-1:0][WIN_W-1:0] wr_val,
   output logic [N-1:0][WIN_W-1:0] q
);
   for (genvar i = 0; i < N; i++) begin : g_win
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     q[i] <= '0;
         else if (wr[i]) q[i] <= wr_val[i];
      end
   end
endmodule

// File: rtl/pcib_bringup.sv
module pcib_bringup
   import pcib_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 200_000_000,
   parameter int unsigned TIME_DIV    = 1,
   parameter int unsigned RST_HOLD_US = 150,
   parameter int unsigned ARB_HOLD_US = 1,
   parameter int unsigned SETTLE_US   = 10_000,
   parameter int unsigned WIN_W       = 32,
   parameter logic [31:0] IO_BASE     = 32'h0800_0000,
   parameter logic [31:0] CFG_BASE    = 32'h0C00_0000,
   parameter logic [31:0] MEM_BASE    = 32'h4000_0000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   output logic             bus_rst_oe,
   output logic             bus_clk_oe,
   output logic             bus_clk_run,
   output logic             bus_rst_release,
   output logic             arb_internal,
   output logic [WIN_W-1:0] win_io,
   output logic [WIN_W-1:0] win_cfg,
   output logic [WIN_W-1:0] win_mem,
   output logic             ready
);
   localparam int unsigned CLK_MHZ    = CLK_HZ / 1_000_000;
   localparam int unsigned HOLD_CYC   = delay_cycles(CLK_MHZ, RST_HOLD_US, TIME_DIV);
   localparam int unsigned ARB_CYC    = delay_cycles(CLK_MHZ, ARB_HOLD_US, TIME_DIV);
   localparam int unsigned SETTLE_CYC = delay_cycles(CLK_MHZ, SETTLE_US, TIME_DIV);
   localparam int unsigned MAX_A      = (HOLD_CYC > ARB_CYC) ? HOLD_CYC : ARB_CYC;
   localparam int unsigned MAX_CYC    = (MAX_A > SETTLE_CYC) ? MAX_A : SETTLE_CYC;
   localparam int unsigned CNT_W      = $clog2(MAX_CYC + 1);
   localparam logic [31:0] SIZE64M_M  = 32'h03FF_FFFF;
   localparam logic [31:0] SIZE1G_M   = 32'h3FFF_FFFF;

   if (CLK_HZ % 1_000_000 != 0) begin : g_bad_clk
      $error("CLK_HZ must be a whole number of MHz");
   end
   if (TIME_DIV < 1) begin : g_bad_div
      $error("TIME_DIV must be at least 1");
   end
   if (WIN_W != 32) begin : g_bad_w
      $error("WIN_W must be 32");
   end
   if (((IO_BASE & SIZE64M_M) != 0) || ((CFG_BASE & SIZE64M_M) != 0)) begin : g_bad_a64
      $error("64 MB windows must be 64 MB aligned");
   end
   if ((MEM_BASE & SIZE1G_M) != 0) begin : g_bad_a1g
      $error("1 GB window must be 1 GB aligned");
   end

   logic                    tmr_load, tmr_zero, done;
   logic [CNT_W-1:0]        tmr_val;
   bus_ctl_t                ctl;
   logic [NUM_WIN-1:0]      win_wr;
   logic [NUM_WIN-1:0][WIN_W-1:0] win_val, win_q;

   assign win_val[WIN_IDX_IO]  = WIN_W'(IO_BASE  | {30'd0, WTYPE_IO});
   assign win_val[WIN_IDX_CFG] = WIN_W'(CFG_BASE | {30'd0, WTYPE_CFG0});
   assign win_val[WIN_IDX_MEM] = WIN_W'(MEM_BASE | {30'd0, WTYPE_MEM});

   pcib_seq_fsm #(
      .CNT_W(CNT_W), .HOLD_CYC(HOLD_CYC), .ARB_CYC(ARB_CYC), .SETTLE_CYC(SETTLE_CYC)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .tmr_zero(tmr_zero),
      .tmr_load(tmr_load), .tmr_val(tmr_val), .ctl(ctl), .win_wr(win_wr), .done(done)
   );

   pcib_delay_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
   );

   pcib_window_regs #(.N(NUM_WIN), .WIN_W(WIN_W)) u_win (
      .clk(clk), .rst_n(rst_n), .wr(win_wr), .wr_val(win_val), .q(win_q)
   );

   assign bus_rst_oe      = ctl.rst_oe;
   assign bus_clk_oe      = ctl.clk_oe;
   assign bus_clk_run     = ctl.clk_run;
   assign bus_rst_release = ctl.rst_rel;
   assign arb_internal    = ctl.arb_int;
   assign win_io          = win_q[WIN_IDX_IO];
   assign win_cfg         = win_q[WIN_IDX_CFG];
   assign win_mem         = win_q[WIN_IDX_MEM];
   assign ready           = done;
endmodule

// File: rtl/pcib_bringup_chk.sv
module pcib_bringup_chk #(
   parameter int unsigned WIN_W      = 32,
   parameter int unsigned HOLD_CYC   = 4,
   parameter int unsigned ARB_CYC    = 1,
   parameter int unsigned SETTLE_CYC = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_rst_oe,
   input logic             bus_clk_oe,
   input logic             bus_clk_run,
   input logic             bus_rst_release,
   input logic             arb_internal,
   input logic [WIN_W-1:0] win_io,
   input logic [WIN_W-1:0] win_cfg,
   input logic [WIN_W-1:0] win_mem,
   input logic             ready
);
   int unsigned hold_cnt, arb_cnt, settle_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_cnt   <= 0;
         arb_cnt    <= 0;
         settle_cnt <= 0;
      end else begin
         hold_cnt   <= (bus_clk_run && !bus_rst_release) ? hold_cnt + 1 : 0;
         arb_cnt    <= (arb_internal && win_io == '0) ? arb_cnt + 1 : 0;
         settle_cnt <= (win_mem != '0 && !ready) ? settle_cnt + 1 : 0;
      end
   end

   // R2
   drivers_before_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_clk_run |-> (bus_rst_oe && bus_clk_oe));

   // R3
   clock_before_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst_release |-> bus_clk_run);

   // R4
   reset_hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_rst_release) |-> (hold_cnt == HOLD_CYC));

   // R5
   arb_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arb_internal |-> bus_rst_release);

   // R5
   arb_hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (win_io != '0 && $past(win_io) == '0) |-> (arb_cnt == ARB_CYC + 1));

   // R6
   window_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((win_cfg != '0) |-> (win_io != '0)) and ((win_mem != '0) |-> (win_cfg != '0)));

   // R7
   settle_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> (settle_cnt == SETTLE_CYC));

   // R7
   ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);

   // R8
   ready_outputs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ($stable(win_io) && $stable(win_cfg) && $stable(win_mem) && arb_internal));
endmodule

bind pcib_bringup pcib_bringup_chk #(
   .WIN_W(WIN_W), .HOLD_CYC(HOLD_CYC), .ARB_CYC(ARB_CYC), .SETTLE_CYC(SETTLE_CYC)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_rst_oe(bus_rst_oe), .bus_clk_oe(bus_clk_oe),
   .bus_clk_run(bus_clk_run), .bus_rst_release(bus_rst_release),
   .arb_internal(arb_internal), .win_io(win_io), .win_cfg(win_cfg),
   .win_mem(win_mem), .ready(ready)
);

// File: tb/pcib_bringup_bench.sv
module pcib_bringup_bench;
   localparam int unsigned TDIV = 100;
   localparam int unsigned MHZ  = 200;

   function automatic int clampc(input int v);
      return (v < 1) ? 1 : v;
   endfunction

   localparam int H = clampc(MHZ * 150 / TDIV);
   localparam int A = clampc(MHZ * 1 / TDIV);
   localparam int S = clampc(MHZ * 10000 / TDIV);

   localparam logic [31:0] EXP_IO  = 32'h0800_0001;
   localparam logic [31:0] EXP_CFG = 32'h0C00_0002;
   localparam logic [31:0] EXP_MEM = 32'h4000_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic bus_rst_oe, bus_clk_oe, bus_clk_run, bus_rst_release, arb_internal, ready;
   logic [31:0] win_io, win_cfg, win_mem;

   always #2.5 clk = ~clk;

   pcib_bringup #(.CLK_HZ(200_000_000), .TIME_DIV(TDIV)) u_pcib_bringup (
      .clk(clk), .rst_n(rst_n), .start(start),
      .bus_rst_oe(bus_rst_oe), .bus_clk_oe(bus_clk_oe), .bus_clk_run(bus_clk_run),
      .bus_rst_release(bus_rst_release), .arb_internal(arb_internal),
      .win_io(win_io), .win_cfg(win_cfg), .win_mem(win_mem), .ready(ready)
   );

   int checks = 0;
   int errors = 0;
   int cyc_now = 0;

   int          q_cyc[$];
   logic [8:0]  q_vec[$];
   string       q_req[$];
   logic [8:0]  prev_vec = '0;

   always @(posedge clk) cyc_now <= cyc_now + 1;

   function automatic logic [8:0] cur_vec();
      return {ready, win_mem != 0, win_cfg != 0, win_io != 0,
              arb_internal, bus_rst_release, bus_clk_run, bus_clk_oe, bus_rst_oe};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic push(input int c, input logic [8:0] v, input string r);
      q_cyc.push_back(c);
      q_vec.push_back(v);
      q_req.push_back(r);
   endtask

   // Driver: expected timeline of output changes, then the start pulse
   task automatic run_seq();
      int t0;
      @(negedge clk);
      t0 = cyc_now + 1;
      push(t0,               9'b000000011, "R2");
      push(t0 + 1,           9'b000000111, "R3");
      push(t0 + 1 + H,       9'b000001111, "R4");
      push(t0 + 2 + H,       9'b000011111, "R5");
      push(t0 + 3 + H + A,   9'b000111111, "R6");
      push(t0 + 4 + H + A,   9'b001111111, "R6");
      push(t0 + 5 + H + A,   9'b011111111, "R6");
      push(t0 + 5 + H + A + S, 9'b111111111, "R7");
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // Monitor: every change of the output vector must match the next expected item
   always @(negedge clk) begin
      logic [8:0] v;
      v = cur_vec();
      if (rst_n && v !== prev_vec) begin
         if (q_cyc.size() == 0) begin
            check(1'b0, "R8", "unexpected output change", v, prev_vec);
         end else begin
            int    c;
            logic [8:0] e;
            string r;
            c = q_cyc.pop_front();
            e = q_vec.pop_front();
            r = q_req.pop_front();
            check(v === e, r, "output vector", v, e);
            check(cyc_now == c, r, "change cycle", cyc_now, c);
         end
      end
      prev_vec = v;
   end

   task automatic check_windows(input string tag);
      check(win_io  === EXP_IO,  "R6", {tag, " io window"},  win_io,  EXP_IO);
      check(win_cfg === EXP_CFG, "R6", {tag, " cfg window"}, win_cfg, EXP_CFG);
      check(win_mem === EXP_MEM, "R6", {tag, " mem window"}, win_mem, EXP_MEM);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      check(cur_vec() === 9'd0 && win_io === 0, "R1", "outputs in reset", cur_vec(), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(cur_vec() === 9'd0 && win_cfg === 0 && win_mem === 0, "R1",
            "outputs after reset", cur_vec(), 0);

      // Full run with a stray start pulse during the reset hold
      run_seq();
      repeat (H / 2) @(negedge clk);
      start = 1'b1;                 // R8: ignored while running
      @(negedge clk);
      start = 1'b0;
      wait (ready === 1'b1);
      repeat (2) @(negedge clk);
      check(q_cyc.size() == 0, "R7", "timeline fully consumed", q_cyc.size(), 0);
      check_windows("run1");

      // Start pulse after ready
      start = 1'b1;                 // R8: ignored after ready
      @(negedge clk);
      start = 1'b0;
      repeat (H + 20) @(negedge clk);
      check(cur_vec() === 9'h1FF, "R8", "outputs after late start", cur_vec(), 9'h1FF);
      check_windows("late start");

      // Reset in the middle of the hold, then a fresh run
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run_seq();
      repeat (H / 2) @(negedge clk);
      rst_n = 1'b0;
      #1;
      check(cur_vec() === 9'd0, "R9", "outputs on mid-run reset", cur_vec(), 0);
      check(win_io === 0, "R9", "io window on mid-run reset", win_io, 0);
      q_cyc.delete();
      q_vec.delete();
      q_req.delete();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (H + 10) @(negedge clk);
      check(cur_vec() === 9'd0, "R9", "idle after reset release", cur_vec(), 0);
      run_seq();
      wait (ready === 1'b1);
      repeat (2) @(negedge clk);
      check(q_cyc.size() == 0, "R9", "rerun timeline consumed", q_cyc.size(), 0);
      check_windows("rerun");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200_000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule